// File: doc/BRIEF.md
# Muon Candidate Merge and Rank Sorter

Three independent muon track-finder subsystems each report a fixed list of candidate muons for every bunch crossing. The same physical muon is often seen by more than one of these subsystems, so the block first cross-matches candidates coming from different subsystems. Two candidates match when they lie close together in eta and in phi. From each matched group only the higher-quality member is kept.

The surviving candidates are then ranked. Higher transverse-momentum code ranks first, then higher quality. The four best are presented on the output, ordered best first, for the global decision logic. A new set of candidates is accepted on every clock cycle, one per crossing, and each result appears after a fixed pipeline latency.

The two matching windows are inputs. They are captured together with the candidates they apply to. The isolation bit and the charge bit are not interpreted; they travel with the candidate that carries them.

Top module: `mu_merge_sort`

## Requirements
- R1: Each 25-bit candidate word is laid out as pt[24:20], charge[19], eta[18:13], phi[12:5], quality[4:2], isolation[1], valid[0]. Input candidate slot s of subsystem y sits at flat index y*4+s, occupying bits [index*25 +: 25] of `cands_i`. Output slot k occupies bits [k*25 +: 25] of `best_o`, and slot 0 is the best.
- R2: The block accepts a new crossing on every clock edge. The result for the candidates and windows sampled at one rising edge appears on `best_o` right after the fourth rising edge counted from that sampling edge (sampling edge included).
- R3: Two valid candidates from different subsystems match when both of these hold: the absolute difference of their unsigned eta codes is at most `eta_win_i`, and their phi distance is at most `phi_win_i`. A match includes the case where a difference equals its window.
- R4: When two candidates match, the one with higher quality is kept and the other is dropped. On equal quality the lower flat index is kept. Candidates from the same subsystem are never merged with each other.
- R5: Survivors are ranked by pt code, larger first, then by quality, larger first. Any remaining tie goes to the lower flat index, which gives the lower subsystem first and then the lower slot.
- R6: Exactly the four highest-ranked survivors are output, in rank order. Valid output slots are contiguous from slot 0.
- R7: Inputs with the valid bit clear never reach the output, whatever their other fields hold. Output slots without a candidate are all-zero.
- R8: A synchronous active-high reset clears every output slot to zero.
- R9: The charge and isolation bits of a surviving candidate appear unchanged on the output.
- R10: Phi distance wraps around the 256-code circle: it is the smaller of (a-b) mod 256 and (b-a) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| eta_win_i | input | 6 | Eta matching window |
| phi_win_i | input | 8 | Phi matching window |
| cands_i | input | 300 | Twelve candidate words, three subsystems by four slots |
| best_o | output | 100 | Four ranked output candidates |

## Verification
Duplicate removal and the four-slot cut can act in the same crossing. If a duplicate of the strongest muon is not removed, it takes an output slot and pushes the rightful fourth candidate off the list. The bench provokes this with a crossing that holds a matched pair at the highest pt alongside four further candidates of falling pt. The result is judged by comparing all four slots with an independent model that removes duplicates first and then picks by repeated maximum search.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int PT_W   = 5;
  localparam int ETA_W  = 6;
  localparam int PHI_W  = 8;
  localparam int QUAL_W = 3;

  typedef struct packed {
    logic [PT_W-1:0]   pt;
    logic              chg;
    logic [ETA_W-1:0]  eta;
    logic [PHI_W-1:0]  phi;
    logic [QUAL_W-1:0] qual;
    logic              iso;
    logic              vld;
  } mu_cand_t;

  localparam int CAND_W = $bits(mu_cand_t);
endpackage

// File: rtl/mu_match.sv
module mu_match import mu_pkg::*; #(
  parameter int NSYS  = 3,
  parameter int NSLOT = 4,
  localparam int NCAND = NSYS * NSLOT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ETA_W-1:0]         eta_win,
  input  logic [PHI_W-1:0]         phi_win,
  input  mu_cand_t [NCAND-1:0]     cand_i,
  output mu_cand_t [NCAND-1:0]     cand_o
);
  function automatic logic near(input mu_cand_t a, input mu_cand_t b,
                                input logic [ETA_W-1:0] ew, input logic [PHI_W-1:0] pw);
    logic [ETA_W-1:0] de;
    logic [PHI_W-1:0] dp;
    de = (a.eta > b.eta) ? a.eta - b.eta : b.eta - a.eta;
    dp = a.phi - b.phi;
    if (dp[PHI_W-1]) dp = -dp;
    return (de <= ew) && (dp <= pw);
  endfunction

  logic [NCAND-1:0] drop;

  always_comb begin
    for (int i = 0; i < NCAND; i++) begin
      drop[i] = !cand_i[i].vld;
      for (int j = 0; j < NCAND; j++) begin
        if ((i / NSLOT) != (j / NSLOT) && cand_i[i].vld && cand_i[j].vld &&
            near(cand_i[i], cand_i[j], eta_win, phi_win) &&
            ((cand_i[j].qual > cand_i[i].qual) ||
             (cand_i[j].qual == cand_i[i].qual && j < i)))
          drop[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCAND; i++)
      cand_o[i] <= (rst || drop[i]) ? '0 : cand_i[i];
  end

  // R4: after merging, no two survivors from different subsystems still match
  for (genvar gi = 0; gi < NCAND; gi++) begin : g_pi
    for (genvar gj = gi + 1; gj < NCAND; gj++) begin : g_pj
      if ((gi / NSLOT) != (gj / NSLOT)) begin : g_x
        a_r4_no_matched_pair: assert property (@(posedge clk) disable iff (rst)
          !(cand_o[gi].vld && cand_o[gj].vld && !$past(rst) &&
            near(cand_o[gi], cand_o[gj], $past(eta_win), $past(phi_win))));
      end
    end
  end
endmodule

// File: rtl/mu_rank.sv
module mu_rank import mu_pkg::*; #(
  parameter int NCAND = 12,
  localparam int RW = $clog2(NCAND)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mu_cand_t [NCAND-1:0]     cand_i,
  output mu_cand_t [NCAND-1:0]     cand_o,
  output logic [NCAND-1:0][RW-1:0] rank_o
);
  localparam int KW = 1 + PT_W + QUAL_W;

  logic [NCAND-1:0][KW-1:0] key;
  logic [NCAND-1:0][RW-1:0] rank_n;

  always_comb begin
    for (int i = 0; i < NCAND; i++)
      key[i] = {cand_i[i].vld, cand_i[i].pt, cand_i[i].qual};
    for (int i = 0; i < NCAND; i++) begin
      rank_n[i] = '0;
      for (int j = 0; j < NCAND; j++)
        if (key[j] > key[i] || (key[j] == key[i] && j < i))
          rank_n[i] = rank_n[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_o <= '0;
      for (int i = 0; i < NCAND; i++) rank_o[i] <= RW'(i);
    end else begin
      cand_o <= cand_i;
      rank_o <= rank_n;
    end
  end
endmodule

// File: rtl/mu_select.sv
module mu_select import mu_pkg::*; #(
  parameter int NCAND = 12,
  parameter int NOUT  = 4,
  localparam int RW = $clog2(NCAND)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mu_cand_t [NCAND-1:0]     cand_i,
  input  logic [NCAND-1:0][RW-1:0] rank_i,
  output mu_cand_t [NOUT-1:0]      best_o
);
  logic [NCAND-1:0] hit [NOUT];
  mu_cand_t [NOUT-1:0] pick;

  for (genvar k = 0; k < NOUT; k++) begin : g_slot
    always_comb begin
      pick[k] = '0;
      for (int i = 0; i < NCAND; i++) begin
        hit[k][i] = (rank_i[i] == RW'(k));
        if (hit[k][i]) pick[k] = pick[k] | cand_i[i];
      end
    end

    // R6: every output rank is held by exactly one candidate
    a_r6_one_owner: assert property (@(posedge clk) disable iff (rst)
      $countones(hit[k]) == 1);
  end

  always_ff @(posedge clk) begin
    if (rst) best_o <= '0;
    else     best_o <= pick;
  end
endmodule

// File: rtl/mu_merge_sort.sv
module mu_merge_sort import mu_pkg::*; #(
  parameter int NSYS  = 3,
  parameter int NSLOT = 4,
  parameter int NOUT  = 4,
  localparam int NCAND = NSYS * NSLOT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ETA_W-1:0]          eta_win_i,
  input  logic [PHI_W-1:0]          phi_win_i,
  input  logic [NCAND*CAND_W-1:0]   cands_i,
  output logic [NOUT*CAND_W-1:0]    best_o
);
  localparam int RW = $clog2(NCAND);

  mu_cand_t [NCAND-1:0]     in_q;
  logic [ETA_W-1:0]         ew_q;
  logic [PHI_W-1:0]         pw_q;
  mu_cand_t [NCAND-1:0]     merged;
  mu_cand_t [NCAND-1:0]     ranked;
  logic [NCAND-1:0][RW-1:0] rank;
  mu_cand_t [NOUT-1:0]      best;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
      ew_q <= '0;
      pw_q <= '0;
    end else begin
      in_q <= cands_i;
      ew_q <= eta_win_i;
      pw_q <= phi_win_i;
    end
  end

  mu_match #(.NSYS(NSYS), .NSLOT(NSLOT)) u_match (
    .clk(clk), .rst(rst), .eta_win(ew_q), .phi_win(pw_q),
    .cand_i(in_q), .cand_o(merged));

  mu_rank #(.NCAND(NCAND)) u_rank (
    .clk(clk), .rst(rst), .cand_i(merged), .cand_o(ranked), .rank_o(rank));

  mu_select #(.NCAND(NCAND), .NOUT(NOUT)) u_sel (
    .clk(clk), .rst(rst), .cand_i(ranked), .rank_i(rank), .best_o(best));

  assign best_o = best;

  // R8: reset empties the output on the next edge
  a_r8_reset_clear: assert property (@(posedge clk) rst |=> best_o == '0);

  for (genvar k = 0; k + 1 < NOUT; k++) begin : g_chk
    // R6: valid slots are packed from slot 0
    a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
      best[k+1].vld |-> best[k].vld);
    // R5: adjacent valid slots are in non-increasing {pt, quality} order
    a_r5_sorted: assert property (@(posedge clk) disable iff (rst)
      best[k+1].vld |-> {best[k].pt, best[k].qual} >= {best[k+1].pt, best[k+1].qual});
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_zero
    // R7: an empty slot carries no stray field bits
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
      !best[k].vld |-> best[k] == '0);
  end
endmodule

// File: tb/sim_mu_merge_sort.sv
module sim_mu_merge_sort;
  import mu_pkg::*;
  localparam int NSYS = 3, NSLOT = 4, NOUT = 4;
  localparam int NC = NSYS * NSLOT;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ETA_W-1:0] ew = '0;
  logic [PHI_W-1:0] pw = '0;
  logic [NC*CAND_W-1:0] cands = '0;
  logic [NOUT*CAND_W-1:0] best;

  always #5 clk = ~clk;

  mu_merge_sort #(.NSYS(NSYS), .NSLOT(NSLOT), .NOUT(NOUT)) u0 (
    .clk(clk), .rst(rst), .eta_win_i(ew), .phi_win_i(pw),
    .cands_i(cands), .best_o(best));

  typedef struct {
    int due;
    logic [NOUT*CAND_W-1:0] exp;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [NC*CAND_W-1:0] stim;

  function automatic mu_cand_t mk(int pt, int chg, int eta, int phi, int qu, int iso);
    mu_cand_t c;
    c.pt = PT_W'(pt); c.chg = chg[0]; c.eta = ETA_W'(eta); c.phi = PHI_W'(phi);
    c.qual = QUAL_W'(qu); c.iso = iso[0]; c.vld = 1'b1;
    return c;
  endfunction

  function automatic bit close(mu_cand_t a, mu_cand_t b, int e, int p);
    int de, d;
    de = int'(a.eta) - int'(b.eta);
    if (de < 0) de = -de;
    d = (int'(a.phi) - int'(b.phi) + 256) % 256;
    if (256 - d < d) d = 256 - d;
    return (de <= e) && (d <= p);
  endfunction

  function automatic logic [NOUT*CAND_W-1:0] model(logic [NC*CAND_W-1:0] v, int e, int p);
    mu_cand_t c [NC];
    mu_cand_t s [NC];
    bit used [NC];
    logic [NOUT*CAND_W-1:0] r;
    r = '0;
    for (int i = 0; i < NC; i++) begin
      c[i] = v[i*CAND_W +: CAND_W];
      if (!c[i].vld) c[i] = '0;
    end
    for (int i = 0; i < NC; i++) begin
      bit gone;
      gone = 0;
      for (int j = 0; j < NC; j++)
        if (j / NSLOT != i / NSLOT && c[i].vld && c[j].vld && close(c[i], c[j], e, p) &&
            (c[j].qual > c[i].qual || (c[j].qual == c[i].qual && j < i)))
          gone = 1;
      s[i] = gone ? mu_cand_t'('0) : c[i];
      used[i] = 0;
    end
    for (int k = 0; k < NOUT; k++) begin
      int b;
      b = -1;
      for (int i = 0; i < NC; i++)
        if (!used[i] && s[i].vld &&
            (b < 0 || s[i].pt > s[b].pt || (s[i].pt == s[b].pt && s[i].qual > s[b].qual)))
          b = i;
      if (b >= 0) begin
        used[b] = 1;
        r[k*CAND_W +: CAND_W] = s[b];
      end
    end
    return r;
  endfunction

  task automatic put(int sys, int slot, mu_cand_t c);
    stim[(sys*NSLOT+slot)*CAND_W +: CAND_W] = c;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (best !== it.exp) begin
        errors++;
        $display("FAIL %s: got=%h expected=%h", it.tag, best, it.exp);
      end
    end
  endtask

  task automatic send(string tag, int e, int p);
    item_t it;
    ew = ETA_W'(e); pw = PHI_W'(p); cands = stim;
    it.due = cyc + LAT; it.exp = model(stim, e, p); it.tag = tag;
    q.push_back(it);
    stim = '0;
    tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    stim = '0;
    repeat (3) tick();
    checks++;
    if (best !== '0) begin
      errors++;
      $display("FAIL R8 reset: got=%h expected=0", best);
    end
    rst = 1'b0;

    // R1 R2: lone candidate in subsystem 1, slot 2
    put(1, 2, mk(9, 1, 20, 100, 4, 1));
    send("R1 R2 single", 1, 1);

    // R5 R6: twelve distinct pts, far apart, top four kept
    for (int i = 0; i < NC; i++) put(i / NSLOT, i % NSLOT, mk((i*7) % 31 + 1, 0, i*5, i*20, 2, 0));
    send("R5 R6 distinct", 1, 1);

    // R5: equal pt, quality decides
    put(0, 0, mk(12, 0, 0, 0, 1, 0));
    put(1, 1, mk(12, 0, 30, 90, 5, 0));
    put(2, 3, mk(12, 0, 60, 180, 3, 0));
    send("R5 quality tiebreak", 0, 0);

    // R5: full tie, lower index first, five ties truncated to four
    for (int i = 0; i < 5; i++) put(2 - i / 2, i % 2, mk(15, 0, i*10, i*40, 4, i % 2));
    send("R5 R6 index tiebreak", 0, 0);

    // R3 R4 R9: cross-subsystem duplicate, higher quality kept with its chg/iso
    put(0, 0, mk(20, 0, 10, 50, 3, 0));
    put(2, 1, mk(20, 1, 12, 48, 6, 1));
    send("R3 R4 R9 merge", 2, 2);

    // R4: equal quality duplicate, lower index kept
    put(0, 3, mk(18, 0, 10, 50, 5, 0));
    put(1, 0, mk(17, 1, 10, 50, 5, 1));
    send("R4 equal quality merge", 0, 0);

    // R4: same-subsystem neighbours are not merged
    put(1, 0, mk(22, 0, 40, 70, 5, 0));
    put(1, 1, mk(21, 0, 40, 70, 2, 0));
    send("R4 same subsystem kept", 5, 5);

    // R10: phi wrap 254 vs 2 is distance 4
    put(0, 1, mk(10, 0, 5, 254, 2, 0));
    put(1, 2, mk(11, 0, 5, 2, 1, 1));
    send("R10 phi wrap", 0, 4);

    // R3: eta difference equal to window matches, one more does not
    put(0, 0, mk(10, 0, 20, 30, 1, 0));
    put(1, 0, mk(11, 0, 23, 30, 2, 0));
    put(2, 0, mk(12, 0, 27, 30, 3, 0));
    send("R3 window boundary", 3, 0);

    // R6 R4: duplicate of the best muon plus four others compete for four slots
    put(0, 0, mk(30, 0, 8, 8, 2, 0));
    put(1, 3, mk(30, 1, 9, 9, 7, 1));
    put(0, 1, mk(25, 0, 40, 100, 3, 0));
    put(1, 1, mk(24, 0, 50, 150, 3, 0));
    put(2, 2, mk(23, 0, 60, 200, 3, 0));
    put(2, 3, mk(22, 0, 20, 240, 3, 0));
    send("R6 R4 merge with truncation", 1, 1);

    // R7: invalid inputs with busy fields never show
    for (int i = 0; i < NC; i++) begin
      mu_cand_t c;
      c = mk(31, 1, 63, 255, 7, 1);
      c.vld = 1'b0;
      put(i / NSLOT, i % NSLOT, c);
    end
    send("R7 invalid ignored", 63, 255);

    // R2 R3 R5: back-to-back crossings with random content
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < NC; i++)
        stim[i*CAND_W +: CAND_W] = CAND_W'($urandom);
      send("R2 R3 R5 stream", $urandom % 8, $urandom % 16);
    end

    for (int n = 0; n < LAT + 2; n++) send("R7 drain", 0, 0);
    done = 1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      summary();
    end
  end
endmodule